// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five requesters, called localities and numbered 0 to 4, owns a shared security-module register interface at any moment. Each locality reaches a one-byte ownership register through a plain register bus. The locality number is carried in address bits 14:12, and the register sits at offset zero inside that locality's window. A locality asks for the interface by writing its request bit. It gives the interface up by writing the active bit while it is the owner. It learns whether it owns the interface, and whether others are queued behind it, by reading the same register.

At most one locality is active at a time. When the interface is free and requests are queued, the block grants the highest-numbered requester on the next clock. Every change of owner, including the change to no owner at all, produces a one-cycle event for the interrupt logic. The current owner is also brought out on dedicated outputs, so the command and FIFO logic around the block can gate its accesses.

Top module: `locality_arbiter`

## Requirements
- R1: After synchronous reset no locality is active, no request is queued, `owner_valid` and `locality_change` are 0, and `owner_loc` reads 0.
- R2: A read of a mapped ownership register returns its byte one clock after `bus_rd`. Address bits 15 and 11:0 must be zero, and bits 14:12 must hold a locality of 4 or less. Bit 7 of the byte always reads 1. Unused bits read 0. A read of any other address returns 0x00.
- R3: A write with bit 1 (request) set to a locality that is not the owner queues a request for it, and bit 1 of that locality's byte then reads 1.
- R4: While no locality is active and at least one request is queued, the highest-numbered requester becomes owner at the next clock edge and its request is cleared. `owner_loc` gives its number. `owner_loc` is 0 whenever `owner_valid` is 0.
- R5: At most one locality is active. Bit 5 (active) reads 1 only in the owner's byte.
- R6: A write with bit 5 set to the owner's register releases ownership at that edge. The same write to any other locality has no effect.
- R7: Bit 2 (pending) of a locality's byte reads 1 when any other locality has a queued request.
- R8: `locality_change` is high for exactly the one cycle that follows each edge at which the owner changes, including a grant and a release to no owner.
- R9: A request write from the active locality is ignored and queues nothing.
- R10: Writes to unmapped addresses have no effect on requests or ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| owner_valid | output | 1 | A locality is active |
| owner_loc | output | 3 | Number of the active locality (0 when none) |
| locality_change | output | 1 | One-cycle pulse after each change of owner |

## Verification
The bench sweeps every subset of requesters queued behind an owner, then releases owners one by one. This exposes a design that grants in the wrong priority, grants while still owned, or forgets to clear the granted request, which would grant the same locality twice. The bench sends a request write from the owner, which a wrong design would queue, leaving bit 1 set and causing a re-grant after release. It sends a release from a non-owner, which a wrong design would honour by dropping the real owner. It writes to aliased and out-of-range addresses, which a design with a loose address decode would turn into requests. Every cycle the bench compares the change pulse against the modelled owner history, which catches a pulse that is missing on release to no owner or that lasts longer than one cycle.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned ACC_W      = 8;
  localparam int unsigned BIT_VALID  = 7;
  localparam int unsigned BIT_ACTIVE = 5;
  localparam int unsigned BIT_PEND   = 2;
  localparam int unsigned BIT_REQ    = 1;

  typedef logic [ACC_W-1:0] acc_byte_t;
endpackage

// File: rtl/loc_addr_decode.sv
module loc_addr_decode #(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 16,
  parameter int LOC_LSB = 12,
  parameter int LOC_W   = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr,
  input  logic               rd,
  output logic [NUM_LOC-1:0] wr_stb,
  output logic               rd_hit,
  output logic [LOC_W-1:0]   loc_idx
);
  localparam int TOP_LSB = LOC_LSB + LOC_W;

  logic upper_zero;
  logic offset_zero;
  logic in_range;
  logic mapped;

  assign loc_idx     = addr[TOP_LSB-1:LOC_LSB];
  assign offset_zero = (addr[LOC_LSB-1:0] == '0);
  assign in_range    = (int'(loc_idx) < NUM_LOC);

  generate
    if (ADDR_W > TOP_LSB) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:TOP_LSB] == '0);
    end else begin : g_no_upper
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign mapped = upper_zero && offset_zero && in_range;
  assign rd_hit = rd && mapped;

  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_stb
      assign wr_stb[g] = wr && mapped && (loc_idx == LOC_W'(g));
    end
  endgenerate
endmodule

// File: rtl/loc_req_bank.sv
module loc_req_bank #(
  parameter int NUM_LOC = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] set_vec,
  input  logic [NUM_LOC-1:0] clr_vec,
  output logic [NUM_LOC-1:0] req_q
);
  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_req
      always_ff @(posedge clk) begin
        if (rst) begin
          req_q[g] <= 1'b0;
        end else if (clr_vec[g]) begin
          req_q[g] <= 1'b0;
        end else if (set_vec[g]) begin
          req_q[g] <= 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/loc_owner_ctl.sv
module loc_owner_ctl
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LOC-1:0] wr_stb,
  input  acc_byte_t          wdata,
  input  logic [NUM_LOC-1:0] req_q,
  output logic [NUM_LOC-1:0] set_vec,
  output logic [NUM_LOC-1:0] clr_vec,
  output logic               owner_valid,
  output logic [LOC_W-1:0]   owner_idx,
  output logic               loc_change
);
  logic [LOC_W-1:0]   pick;
  logic               grant_now;
  logic               release_now;
  logic [NUM_LOC-1:0] grant_vec;
  logic [NUM_LOC-1:0] own_vec;

  // Highest-numbered queued request wins: later loop iterations override.
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req_q[i]) pick = LOC_W'(i);
    end
  end

  assign grant_now = !owner_valid && (req_q != '0);

  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_vec
      assign grant_vec[g] = grant_now && (pick == LOC_W'(g));
      assign own_vec[g]   = owner_valid && (owner_idx == LOC_W'(g));
    end
  endgenerate

  assign release_now = wdata[BIT_ACTIVE] && ((wr_stb & own_vec) != '0);
  assign set_vec     = wr_stb & {NUM_LOC{wdata[BIT_REQ]}} & ~own_vec & ~grant_vec;
  assign clr_vec     = grant_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_valid <= 1'b0;
      owner_idx   <= '0;
      loc_change  <= 1'b0;
    end else begin
      loc_change <= grant_now || release_now;
      if (release_now) begin
        owner_valid <= 1'b0;
        owner_idx   <= '0;
      end else if (grant_now) begin
        owner_valid <= 1'b1;
        owner_idx   <= pick;
      end
    end
  end
endmodule

// File: rtl/loc_readback.sv
module loc_readback
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_hit,
  input  logic [LOC_W-1:0]   loc_idx,
  input  logic [NUM_LOC-1:0] req_q,
  input  logic               owner_valid,
  input  logic [LOC_W-1:0]   owner_idx,
  output acc_byte_t          rdata
);
  acc_byte_t view [NUM_LOC];
  acc_byte_t sel;

  generate
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_view
      localparam logic [NUM_LOC-1:0] SELF = NUM_LOC'(1) << g;
      always_comb begin
        view[g]             = '0;
        view[g][BIT_VALID]  = 1'b1;
        view[g][BIT_ACTIVE] = owner_valid && (owner_idx == LOC_W'(g));
        view[g][BIT_PEND]   = ((req_q & ~SELF) != '0);
        view[g][BIT_REQ]    = req_q[g];
      end
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (loc_idx == LOC_W'(i)) sel = view[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_hit ? sel : '0;
    end
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 16,
  parameter int LOC_LSB = 12,
  parameter int LOC_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              owner_valid,
  output logic [LOC_W-1:0]  owner_loc,
  output logic              locality_change
);
  logic [NUM_LOC-1:0] wr_stb;
  logic               rd_hit;
  logic [LOC_W-1:0]   loc_idx;
  logic [NUM_LOC-1:0] req_q;
  logic [NUM_LOC-1:0] set_vec;
  logic [NUM_LOC-1:0] clr_vec;

  loc_addr_decode #(
    .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .LOC_W(LOC_W)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_stb(wr_stb), .rd_hit(rd_hit), .loc_idx(loc_idx)
  );

  loc_req_bank #(.NUM_LOC(NUM_LOC)) u_req (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec), .req_q(req_q)
  );

  loc_owner_ctl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_own (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wdata(bus_wdata), .req_q(req_q),
    .set_vec(set_vec), .clr_vec(clr_vec), .owner_valid(owner_valid),
    .owner_idx(owner_loc), .loc_change(locality_change)
  );

  loc_readback #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_rb (
    .clk(clk), .rst(rst), .rd_hit(rd_hit), .loc_idx(loc_idx), .req_q(req_q),
    .owner_valid(owner_valid), .owner_idx(owner_loc), .rdata(bus_rdata)
  );
endmodule

// File: rtl/locality_arbiter_chk.sv
module locality_arbiter_chk #(
  parameter int NUM_LOC = 5,
  parameter int ADDR_W  = 16,
  parameter int LOC_LSB = 12,
  parameter int LOC_W   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic [7:0]         bus_wdata,
  input logic [NUM_LOC-1:0] req_q,
  input logic               owner_valid,
  input logic [LOC_W-1:0]   owner_loc,
  input logic               locality_change
);
  localparam int TOP_LSB = LOC_LSB + LOC_W;

  logic             seen_q;
  logic [LOC_W-1:0] a_loc;
  logic             owner_hit;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  assign a_loc     = bus_addr[TOP_LSB-1:LOC_LSB];
  assign owner_hit = bus_wr && owner_valid && (a_loc == owner_loc) &&
                     (bus_addr[LOC_LSB-1:0] == '0) &&
                     ((bus_addr >> TOP_LSB) == '0);

  assert_change_tracks_owner_R8: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (locality_change ==
      ((owner_valid != $past(owner_valid)) || (owner_loc != $past(owner_loc)))));

  assert_free_grants_R4: assert property (@(posedge clk) disable iff (rst)
    (!owner_valid && (req_q != '0)) |=> (owner_valid && !req_q[owner_loc]));

  assert_owner_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    owner_valid |-> (int'(owner_loc) < NUM_LOC));

  assert_owner_release_R6: assert property (@(posedge clk) disable iff (rst)
    (owner_hit && bus_wdata[5]) |=> !owner_valid);

  assert_owner_request_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (owner_hit && bus_wdata[1] && !bus_wdata[5]) |=> ($stable(req_q) && owner_valid));
endmodule

bind locality_arbiter locality_arbiter_chk #(
  .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_LSB(LOC_LSB), .LOC_W(LOC_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .req_q(req_q), .owner_valid(owner_valid),
  .owner_loc(owner_loc), .locality_change(locality_change)
);

// File: tb/tb_locality_arbiter.sv
module tb_locality_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        ov;
  logic [2:0]  ol;
  logic        chg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          m_own;
  logic [4:0]  m_req;
  logic        m_chg;

  always #(CLK_PERIOD/2) clk = ~clk;

  locality_arbiter dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .owner_valid(ov),
    .owner_loc(ol), .locality_change(chg)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_byte(input int l);
    logic [7:0] b;
    b = 8'h80;
    if (m_own == l) b[5] = 1'b1;
    if ((m_req & ~(5'b1 << l)) != 0) b[2] = 1'b1;
    b[1] = m_req[l];
    return b;
  endfunction

  function automatic int dec(input logic [15:0] a);
    if (a[15] == 1'b0 && a[11:0] == 12'h000 && a[14:12] < 3'd5) return int'(a[14:12]);
    return -1;
  endfunction

  // One bus cycle; model updated per R3/R4/R6/R9/R10, outputs checked after the edge.
  task automatic cyc(input logic w, input logic r, input logic [15:0] a,
                     input logic [7:0] d, input string tag);
    int l;
    int g;
    int n_own;
    logic [4:0] n_req;
    logic [7:0] exp_rd;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    l = dec(a);
    exp_rd = (r && l >= 0) ? model_byte(l) : 8'h00;
    n_own = m_own; n_req = m_req; g = -1;
    if (m_own < 0 && m_req != 0) begin
      for (int i = 0; i < NL; i++) if (m_req[i]) g = i;
      n_own = g;
      n_req[g] = 1'b0;
    end
    if (w && l >= 0) begin
      if (d[1] && l != m_own && l != g) n_req[l] = 1'b1;
      if (d[5] && m_own >= 0 && l == m_own) n_own = -1;
    end
    m_chg = (n_own != m_own);
    m_own = n_own;
    m_req = n_req;
    @(posedge clk);
    #1;
    check({tag, " R5 owner_valid"}, int'(ov), (m_own >= 0) ? 1 : 0);
    check({tag, " R4 owner_loc"}, int'(ol), (m_own >= 0) ? m_own : 0);
    check({tag, " R8 locality_change"}, int'(chg), int'(m_chg));
    if (r) check({tag, " R2 rdata"}, int'(rdata), int'(exp_rd));
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 16'h0000, 8'h00, "idle");
  endtask

  task automatic wr_loc(input int l, input logic [7:0] d, input string tag);
    cyc(1'b1, 1'b0, 16'(l) << 12, d, tag);
  endtask

  task automatic read_all(input string tag);
    for (int l = 0; l < NL; l++) cyc(1'b0, 1'b1, 16'(l) << 12, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_own = -1; m_req = '0; m_chg = 1'b0;
    check("R1 owner_valid after reset", int'(ov), 0);
    check("R1 owner_loc after reset", int'(ol), 0);
    check("R1 change after reset", int'(chg), 0);
    check("R1 rdata after reset", int'(rdata), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state and plain reads (R1, R2)
    do_reset();
    read_all("R1 reset read");

    // Directed sequence
    wr_loc(2, 8'h02, "R3 request loc2");
    idle();                                  // R4 grant of loc2
    read_all("R5 owner loc2");
    wr_loc(4, 8'h02, "R3 request loc4");
    wr_loc(1, 8'h02, "R3 request loc1");
    read_all("R7 pending seen");
    wr_loc(2, 8'h02, "R9 owner request");
    read_all("R9 owner request ignored");
    wr_loc(4, 8'h20, "R6 non-owner release");
    read_all("R6 non-owner release ignored");
    wr_loc(2, 8'h20, "R6 owner release");
    idle();                                  // R4 highest (4) granted
    read_all("R4 highest granted");
    // Unmapped writes (R10)
    cyc(1'b1, 1'b0, 16'h5000, 8'h02, "R10 loc5 write");
    cyc(1'b1, 1'b0, 16'h7000, 8'h22, "R10 loc7 write");
    cyc(1'b1, 1'b0, 16'h0004, 8'h02, "R10 offset write");
    cyc(1'b1, 1'b0, 16'h4008, 8'h20, "R10 owner offset release");
    cyc(1'b1, 1'b0, 16'h8000, 8'h02, "R10 high bit write");
    read_all("R10 state unchanged");
    cyc(1'b0, 1'b1, 16'h5000, 8'h00, "R2 unmapped read");
    cyc(1'b0, 1'b1, 16'h1010, 8'h00, "R2 offset read");
    cyc(1'b0, 1'b1, 16'h9000, 8'h00, "R2 aliased read");

    // Exhaustive sweep of queued subsets behind owner 0
    for (int mask = 0; mask < 32; mask++) begin
      do_reset();
      wr_loc(0, 8'h02, "R3 sweep request loc0");
      idle();
      for (int l = 0; l < NL; l++) if (mask[l]) wr_loc(l, 8'h02, "R3 R9 sweep request");
      idle();
      read_all("R7 sweep queued");
      wr_loc(4, 8'h20, "R6 sweep non-owner release");
      for (int k = 0; k < 7; k++) begin
        if (m_own >= 0) wr_loc(m_own, 8'h20, "R6 sweep release");
        idle();
        read_all("R4 sweep after grant");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule